// File: doc/BRIEF.md
# Three-Latch Configurable Output Register Cell

This block is a behavioural model of an output register cell for a pad. Its storage is a row of three level-sensitive latches. A two-bit mode input chooses how much of that row is used.

- With one latch, the cell is a transparent latch that opens while the clock is high.
- With two latches in opposite phases, it is a rising-edge flip-flop.
- With all three, it is a double-data-rate output register. Both fabric bits are taken on the same rising edge, so they can come from one clock domain. They are then shown on the pad on the two halves of the following clock period.

The DDR pad value comes from a mux whose select is the clock level. The row works as follows:

- The front latch is open while the clock is low, so it holds the fabric bits at the moment of the rising edge.
- The middle latch is open while the clock is high and supplies the high-phase bit.
- The tail latch is open while the clock is low. It copies the low-phase bit from the middle latch, so that bit stays steady through the low half.

The mode is static. It is changed only while reset is held. Reset is active high and clears every latch.

Top module: `lcio_cell`

## Requirements
- R1: While `rst` is high, all three latches are cleared and `pad` reads all zeros in every mode and at either clock level.
- R2: The mode encoding is `mode` = 2'b00 latch, 2'b01 flip-flop, 2'b10 DDR, and 2'b11 reserved.
- R3: In flip-flop mode, `pad` shows the value `d_rise` had just before a rising edge, for the whole clock period that follows. A change of `d_rise` right after the edge does not reach `pad` until the next rising edge.
- R4: In DDR mode, while the clock is high, `pad` shows the value `d_rise` had just before the latest rising edge.
- R5: In DDR mode, while the clock is low, `pad` shows the value `d_fall` had just before the preceding rising edge. The value `d_fall` has at the falling edge has no effect.
- R6: In latch mode, `pad` follows `d_rise` while the clock is high, including changes made after the rising edge.
- R7: In latch mode, `pad` holds the value `d_rise` had at the falling edge for the whole low phase. Changes of `d_rise` during the low phase do not show.
- R8: The reserved mode 2'b11 behaves exactly as the flip-flop mode.
- R9: In latch, flip-flop and reserved modes, `d_fall` has no effect on `pad`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge captures, level drives the DDR output select |
| rst | input | 1 | Active-high reset, clears all latches |
| mode | input | 2 | Static cell mode (see R2) |
| d_rise | input | WIDTH | Fabric data for the high phase (and for latch and flip-flop modes) |
| d_fall | input | WIDTH | Fabric data for the low phase in DDR mode |
| pad | output | WIDTH | Data driven towards the pad |

## Verification
All four mode codes are swept. Each is run with every pairing of a two-bit `d_rise` and `d_fall` value.

Each pair is applied one nanosecond before a rising edge. It is then replaced by its complement half a nanosecond after that edge. Other values are applied after the falling edge. This lets the checks tell apart:

- a value sampled at the rising edge, which is what the flip-flop and DDR modes show;
- a value that passes transparently, which is what the latch mode shows during the high phase;
- a value held from the falling edge, which is what the latch mode shows during the low phase.

The low-phase DDR checks expect the `d_fall` value present before the rising edge and not the one present at the falling edge. This separates a same-edge register from two opposite-edge flip-flops.

// File: rtl/lcio_pkg.sv
package lcio_pkg;

    typedef enum logic [1:0] {
        MODE_LATCH = 2'b00,
        MODE_FLOP  = 2'b01,
        MODE_DDR   = 2'b10,
        MODE_RSVD  = 2'b11
    } lcio_mode_e;

    // Which parts of the latch row are in use for a given mode.
    typedef struct packed {
        logic use_front;   // front (low-open) latch feeds the middle latch
        logic use_tail;    // tail (low-open) latch carries the low-phase bit
        logic clk_select;  // pad mux is steered by the clock level
    } lcio_route_t;

    function automatic lcio_route_t lcio_decode(input logic [1:0] m);
        lcio_route_t r;
        case (lcio_mode_e'(m))
            MODE_LATCH: r = '{use_front: 1'b0, use_tail: 1'b0, clk_select: 1'b0};
            MODE_DDR:   r = '{use_front: 1'b1, use_tail: 1'b1, clk_select: 1'b1};
            default:    r = '{use_front: 1'b1, use_tail: 1'b0, clk_select: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lcio_latch.sv
module lcio_latch #(
    parameter int  WIDTH     = 1,
    parameter bit  OPEN_HIGH = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic open_now;
    assign open_now = (clk == OPEN_HIGH);

    always_latch begin
        if (rst)
            q = '0;
        else if (open_now)
            q = d;
    end
endmodule

// File: rtl/lcio_outmux.sv
module lcio_outmux #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             clk_select,
    input  logic [WIDTH-1:0] high_bits,
    input  logic [WIDTH-1:0] low_bits,
    output logic [WIDTH-1:0] pad
);
    logic pick_high;
    assign pick_high = clk_select ? clk : 1'b1;

    always_comb begin
        pad = pick_high ? high_bits : low_bits;
    end
endmodule

// File: rtl/lcio_cell.sv
module lcio_cell
    import lcio_pkg::*;
#(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] d_rise,
    input  logic [WIDTH-1:0] d_fall,
    output logic [WIDTH-1:0] pad
);
    localparam int PAIR_W = 2 * WIDTH;

    lcio_route_t       route;
    logic [PAIR_W-1:0] front_q;
    logic [PAIR_W-1:0] mid_d;
    logic [PAIR_W-1:0] mid_q;
    logic [WIDTH-1:0]  tail_d;
    logic [WIDTH-1:0]  tail_q;

    assign route = lcio_decode(mode);

    // Front latch: open while clock is low, closes at the rising edge.
    lcio_latch #(.WIDTH(PAIR_W), .OPEN_HIGH(1'b0)) u_front (
        .clk (clk),
        .rst (rst),
        .d   ({d_rise, d_fall}),
        .q   (front_q)
    );

    // Latch mode bypasses the front latch and feeds the middle one directly.
    assign mid_d = route.use_front ? front_q : {d_rise, {WIDTH{1'b0}}};

    // Middle latch: open while clock is high.
    lcio_latch #(.WIDTH(PAIR_W), .OPEN_HIGH(1'b1)) u_mid (
        .clk (clk),
        .rst (rst),
        .d   (mid_d),
        .q   (mid_q)
    );

    // Tail latch only carries the low-phase bit in DDR mode.
    assign tail_d = route.use_tail ? mid_q[WIDTH-1:0] : '0;

    lcio_latch #(.WIDTH(WIDTH), .OPEN_HIGH(1'b0)) u_tail (
        .clk (clk),
        .rst (rst),
        .d   (tail_d),
        .q   (tail_q)
    );

    lcio_outmux #(.WIDTH(WIDTH)) u_mux (
        .clk        (clk),
        .clk_select (route.clk_select),
        .high_bits  (mid_q[PAIR_W-1:WIDTH]),
        .low_bits   (tail_q),
        .pad        (pad)
    );
endmodule

// File: rtl/lcio_cell_chk.sv
module lcio_cell_chk #(
    parameter int WIDTH = 1
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode,
    input logic [WIDTH-1:0] d_rise,
    input logic [WIDTH-1:0] d_fall,
    input logic [WIDTH-1:0] pad
);
    logic             rise_seen;
    logic             fall_seen;
    logic [WIDTH-1:0] cap_r;
    logic [WIDTH-1:0] cap_f;
    logic [WIDTH-1:0] held_r;
    logic             is_ff;
    logic             is_ddr;
    logic             is_lat;

    assign is_ff  = (mode == 2'b01) || (mode == 2'b11);
    assign is_ddr = (mode == 2'b10);
    assign is_lat = (mode == 2'b00);

    always_ff @(posedge clk) begin
        rise_seen <= !rst;
        cap_r     <= d_rise;
        cap_f     <= d_fall;
    end

    always_ff @(negedge clk) begin
        fall_seen <= !rst;
        held_r    <= d_rise;
    end

    AST_RESET_CLEAR: assert property (@(negedge clk)
        rst |-> (pad == '0)); // R1

    AST_FF_HIGH: assert property (@(negedge clk) disable iff (rst)
        (rise_seen && is_ff) |-> (pad == cap_r)); // R3

    AST_FF_LOW: assert property (@(posedge clk) disable iff (rst)
        (rise_seen && is_ff) |-> (pad == cap_r)); // R8

    AST_DDR_HIGH: assert property (@(negedge clk) disable iff (rst)
        (rise_seen && is_ddr) |-> (pad == cap_r)); // R4

    AST_DDR_LOW: assert property (@(posedge clk) disable iff (rst)
        (rise_seen && is_ddr) |-> (pad == cap_f)); // R5

    AST_LATCH_OPEN: assert property (@(negedge clk) disable iff (rst)
        is_lat |-> (pad == d_rise)); // R6

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fall_seen && is_lat) |-> (pad == held_r)); // R7
endmodule

bind lcio_cell lcio_cell_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .d_rise (d_rise),
    .d_fall (d_fall),
    .pad    (pad)
);

// File: tb/lcio_cell_bench.sv
`timescale 1ns/1ps
module lcio_cell_bench;
    localparam int W = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   mode = 2'b01;
    logic [W-1:0] d_rise = '0;
    logic [W-1:0] d_fall = '0;
    logic [W-1:0] pad;

    int checks = 0;
    int fails  = 0;

    lcio_cell #(.WIDTH(W)) u_lcio_cell (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .d_rise (d_rise),
        .d_fall (d_fall),
        .pad    (pad)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [W-1:0] exp);
        checks++;
        if (pad !== exp) begin
            fails++;
            $display("FAIL %s mode=%0d t=%0t pad=%b expected=%b", tag, mode, $time, pad, exp);
        end
    endtask

    task automatic run_mode(input logic [1:0] m);
        logic         pr_r, pr_f;
        logic [W-1:0] p_pre_r, p_pre_f, p_post_r;
        logic         has_prev;
        // reset phase, R1
        rst  = 1'b1;
        mode = m;
        for (int k = 0; k < 2; k++) begin
            @(posedge clk); #1.25; check("R1 reset high phase", '0);
            @(negedge clk); #1.25; check("R1 reset low phase", '0);
        end
        rst = 1'b0;
        has_prev = 1'b0;
        p_pre_r = '0; p_pre_f = '0; p_post_r = '0;
        pr_r = 1'b0; pr_f = 1'b0;
        for (int i = 0; i < 17; i++) begin
            logic [W-1:0] pre_r, pre_f, post_r, post_f, exp_lo, exp_hi;
            pre_r  = W'(i >> 2);
            pre_f  = W'(i);
            post_r = ~pre_r;
            post_f = ~pre_f;
            @(negedge clk); #0.5;
            if (has_prev) begin
                d_rise = p_pre_r;           // differs from held latch value
                d_fall = p_pre_f ^ W'(1);   // later changes in low phase
            end
            #0.75;
            if (has_prev) begin
                case (m)
                    2'b00: begin exp_lo = p_post_r; check("R7 R9 latch holds in low phase", exp_lo); end
                    2'b10: begin exp_lo = p_pre_f;  check("R5 ddr low phase shows d_fall from rising edge", exp_lo); end
                    2'b11: begin exp_lo = p_pre_r;  check("R8 R9 reserved acts as flop, low phase", exp_lo); end
                    default: begin exp_lo = p_pre_r; check("R3 R9 flop holds in low phase", exp_lo); end
                endcase
            end
            if (i == 16) break;
            #0.25;
            d_rise = pre_r;
            d_fall = pre_f;
            @(posedge clk); #0.5;
            d_rise = post_r;
            d_fall = post_f;
            #0.75;
            case (m)
                2'b00: begin exp_hi = post_r; check("R6 latch transparent in high phase", exp_hi); end
                2'b10: begin exp_hi = pre_r;  check("R4 ddr high phase shows d_rise from rising edge", exp_hi); end
                2'b11: begin exp_hi = pre_r;  check("R8 R2 reserved acts as flop, high phase", exp_hi); end
                default: begin exp_hi = pre_r; check("R3 R2 flop ignores change after edge", exp_hi); end
            endcase
            p_pre_r  = pre_r;
            p_pre_f  = pre_f;
            p_post_r = post_r;
            has_prev = 1'b1;
        end
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int m = 0; m < 4; m++) begin
            run_mode(2'(m));
        end
        // back into reset at the end, R1
        rst = 1'b1;
        #1;
        check("R1 reset clears during run", '0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule